// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps one table entry per interrupt vector (a 64-bit message address, a 32-bit message payload and a control word whose bit 0 masks the vector) together with a packed array of pending flags. Software reaches both through a 32-bit slave port that only moves whole dwords. Device logic raises per-vector request lines. A rising request on an enabled, unmasked vector becomes one outgoing message: an address/payload pair offered on a valid/ready handshake.

A request that arrives while the vector is masked, or while the function-wide mask is set, is not lost. It is recorded as a pending flag. The flag is released later when software rewrites any dword of that vector's entry, or when the external sweep strobe asks for every vector to be re-examined. The global enable and the function-wide mask are inputs driven by a separate capability register block. Several vectors can become deliverable in the same cycle. Their messages then leave one per handshake, lowest vector index first.

Top module: `msixvt_top`

## Requirements
- R1: After reset every table dword and every pending-array dword reads as zero, and `msgValid` is low.
- R2: The entry of vector v occupies bytes v*16 to v*16+15. Offset +0 holds the address low dword, +4 the address high dword, +8 the payload and +12 the control word. A dword write there reads back unchanged, including address bits 1:0. Address bits 1:0 of the port are ignored.
- R3: A 0-to-1 change of `irqReq[v]` produces exactly one message when all of these hold: `globalEn` is high, `funcMask` is low and control bit 0 of vector v is clear. The message address is {address high, address low with bits 1:0 forced to 0} and the payload is the entry's payload dword.
- R4: A request line held high produces no further messages. A new message needs a new 0-to-1 change.
- R5: A 0-to-1 change of a request while `globalEn` is low has no effect: no message is sent and no pending flag is set.
- R6: A 0-to-1 change of a request while `funcMask` is high or control bit 0 of the vector is set sends no message and sets the vector's pending flag. The flag of vector v is bit (v mod 32) of the dword at byte offset NUM_VEC*16 + 4*(v/32).
- R7: One cycle after a write lands anywhere in vector v's entry, vector v is re-examined. If its pending flag is set and its control bit 0 is clear, its message is sent and the flag is cleared. `funcMask` is not consulted by this re-examination.
- R8: A one-cycle `sweepReq` pulse re-examines every vector in the same way as R7. Each pending vector with control bit 0 clear is delivered and its flag cleared. Flags of masked vectors stay set.
- R9: Writes at byte offsets from NUM_VEC*16 upward are dropped. They change neither the pending array nor the table.
- R10: Reads inside the mapped region past the pending array return zero. The region is the table plus the pending bytes, rounded up to a multiple of 4096. Reads at or beyond the region's end return 32'hFFFFFFFF.
- R11: Messages that become deliverable together leave one per handshake in ascending vector order. While `msgValid` is high and `msgReady` is low, `msgValid`, `msgAddr` and `msgData` hold their values.
- R12: A rising request that is delivered at once also clears a pending flag the vector held from an earlier masked request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Dword write strobe |
| busRdEn | input | 1 | Dword read strobe; read data is returned in the same cycle |
| busAddr | input | ADDR_W | Byte address within the window (bits 1:0 ignored) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data (zero when `busRdEn` is low) |
| irqReq | input | NUM_VEC | Per-vector request levels; the rising edge is the event |
| globalEn | input | 1 | Global enable from the capability block |
| funcMask | input | 1 | Function-wide mask from the capability block |
| sweepReq | input | 1 | Pulse: re-examine every pending vector |
| msgValid | output | 1 | Outgoing message available |
| msgReady | input | 1 | Consumer accepts the message |
| msgAddr | output | 64 | Message address, bits 1:0 always zero |
| msgData | output | 32 | Message payload |

## Verification
The bound checker watches the output handshake on every cycle. It checks that a stalled message holds its address and payload, and that an offered address is dword aligned. For every vector it also checks that a masked rising request leaves the pending flag set on the next cycle, and that a sweep clears the flag of an unmasked pending vector. Only the bench scenarios can show the rest: the exact contents and count of messages, the ascending delivery order, and re-examination after table writes. They also show what is ignored, namely disabled requests, held levels and writes into the pending array, together with the readback layout and the all-ones reads past the region.

// File: rtl/msixvt_pkg.sv
package msixvt_pkg;

  // Width of a vector index carried between control and datapath
  localparam int VEC_IDX_W = 11;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 load;  // capture entry into the message register
    logic [VEC_IDX_W-1:0] vec;   // entry to capture
  } msgStrobe_t;

  // Table plus pending bytes, rounded up to whole 4 KiB pages
  function automatic int regionBytes(input int nVec);
    int raw;
    raw = nVec * 16 + (nVec + 7) / 8;
    return ((raw + 4095) / 4096) * 4096;
  endfunction

endpackage

// File: rtl/msixvt_datapath.sv
module msixvt_datapath
  import msixvt_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [NUM_VEC-1:0]   pendBits,
  input  msgStrobe_t           strobe,
  output logic [NUM_VEC-1:0]   vecMask,
  output logic                 recheckStb,
  output logic [VEC_IDX_W-1:0] recheckVec,
  output logic [63:0]          msgAddr,
  output logic [31:0]          msgData
);

  localparam int          VSEL_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int          PBA_DW    = (NUM_VEC + 31) / 32;
  localparam logic [31:0] TBL_BYTES = 32'(NUM_VEC * 16);
  localparam logic [31:0] PBA_END   = 32'(NUM_VEC * 16 + PBA_DW * 4);
  localparam logic [31:0] REGION    = 32'(regionBytes(NUM_VEC));

  logic [31:0] loQ  [NUM_VEC];
  logic [31:0] hiQ  [NUM_VEC];
  logic [31:0] datQ [NUM_VEC];
  logic [31:0] ctlQ [NUM_VEC];

  logic [31:0]          addrExt;
  logic [VSEL_W-1:0]    vecSel;
  logic [1:0]           field;
  logic                 tblHit;
  logic                 tblWr;
  logic [31:0]          pbaIdx;
  logic [PBA_DW*32-1:0] pendPad;
  logic [31:0]          rdVal;
  logic [VSEL_W-1:0]    ldSel;

  assign addrExt = 32'(busAddr);
  assign vecSel  = addrExt[4 +: VSEL_W];
  assign field   = addrExt[3:2];
  assign tblHit  = (addrExt < TBL_BYTES);
  assign tblWr   = busWrEn && tblHit;
  assign pbaIdx  = (addrExt - TBL_BYTES) >> 2;
  assign pendPad = {{(PBA_DW*32-NUM_VEC){1'b0}}, pendBits};
  assign ldSel   = strobe.vec[VSEL_W-1:0];

  // Table storage; writes into the pending range fall outside tblHit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        loQ[v]  <= '0;
        hiQ[v]  <= '0;
        datQ[v] <= '0;
        ctlQ[v] <= '0;
      end
    end else if (tblWr) begin
      case (field)
        2'd0:    loQ[vecSel]  <= busWrData;
        2'd1:    hiQ[vecSel]  <= busWrData;
        2'd2:    datQ[vecSel] <= busWrData;
        default: ctlQ[vecSel] <= busWrData;
      endcase
    end
  end

  // Re-examination request one cycle after the entry update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      recheckStb <= 1'b0;
      recheckVec <= '0;
    end else begin
      recheckStb <= tblWr;
      recheckVec <= VEC_IDX_W'(vecSel);
    end
  end

  generate
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_mask
      assign vecMask[g] = ctlQ[g][0];
    end
  endgenerate

  // Read mux
  always_comb begin
    rdVal = '1;
    if (tblHit) begin
      case (field)
        2'd0:    rdVal = loQ[vecSel];
        2'd1:    rdVal = hiQ[vecSel];
        2'd2:    rdVal = datQ[vecSel];
        default: rdVal = ctlQ[vecSel];
      endcase
    end else if (addrExt < PBA_END) begin
      rdVal = '0;
      for (int j = 0; j < PBA_DW; j++) begin
        if (pbaIdx == 32'(j)) rdVal = pendPad[j*32 +: 32];
      end
    end else if (addrExt < REGION) begin
      rdVal = '0;
    end
  end

  assign busRdData = busRdEn ? rdVal : '0;

  // Outgoing message register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddr <= '0;
      msgData <= '0;
    end else if (strobe.load) begin
      msgAddr <= {hiQ[ldSel], loQ[ldSel][31:2], 2'b00};
      msgData <= datQ[ldSel];
    end
  end

endmodule

// File: rtl/msixvt_control.sv
module msixvt_control
  import msixvt_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_VEC-1:0]   irqReq,
  input  logic                 globalEn,
  input  logic                 funcMask,
  input  logic                 sweepReq,
  input  logic [NUM_VEC-1:0]   vecMask,
  input  logic                 recheckStb,
  input  logic [VEC_IDX_W-1:0] recheckVec,
  input  logic                 msgReady,
  output logic                 msgValid,
  output logic [NUM_VEC-1:0]   pendBits,
  output msgStrobe_t           strobe
);

  logic [NUM_VEC-1:0]   irqPrev;
  logic [NUM_VEC-1:0]   pendQ;
  logic [NUM_VEC-1:0]   fireQ;
  logic                 validQ;

  logic [NUM_VEC-1:0]   rise;
  logic [NUM_VEC-1:0]   effMask;
  logic [NUM_VEC-1:0]   maskedRise;
  logic [NUM_VEC-1:0]   cleanRise;
  logic [NUM_VEC-1:0]   recheckHit;
  logic [NUM_VEC-1:0]   releaseVec;
  logic [NUM_VEC-1:0]   grantOH;
  logic [VEC_IDX_W-1:0] pickIdx;
  logic                 pickAny;
  logic                 load;

  // Sampled every cycle, also in reset: a level held through reset is no edge
  always_ff @(posedge clk) irqPrev <= irqReq;

  assign rise       = irqReq & ~irqPrev & {NUM_VEC{globalEn}};
  assign effMask    = funcMask ? {NUM_VEC{1'b1}} : vecMask;
  assign maskedRise = rise & effMask;
  assign cleanRise  = rise & ~effMask;

  generate
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_hit
      assign recheckHit[g] = recheckStb && (recheckVec == VEC_IDX_W'(g));
      assign grantOH[g]    = load && (pickIdx == VEC_IDX_W'(g));
    end
  endgenerate

  assign releaseVec = (recheckHit | {NUM_VEC{sweepReq}}) & pendQ & ~vecMask;

  // Lowest index wins
  always_comb begin
    pickAny = 1'b0;
    pickIdx = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (fireQ[v]) begin
        pickAny = 1'b1;
        pickIdx = VEC_IDX_W'(v);
      end
    end
  end

  assign load = pickAny && (!validQ || msgReady);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      fireQ  <= '0;
      validQ <= 1'b0;
    end else begin
      pendQ  <= (pendQ & ~releaseVec & ~cleanRise) | maskedRise;
      fireQ  <= (fireQ & ~grantOH) | cleanRise | releaseVec;
      if (load)          validQ <= 1'b1;
      else if (msgReady) validQ <= 1'b0;
    end
  end

  assign msgValid    = validQ;
  assign pendBits    = pendQ;
  assign strobe.load = load;
  assign strobe.vec  = pickIdx;

endmodule

// File: rtl/msixvt_top.sv
module msixvt_top
  import msixvt_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [NUM_VEC-1:0] irqReq,
  input  logic               globalEn,
  input  logic               funcMask,
  input  logic               sweepReq,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData
);

  logic [NUM_VEC-1:0]   pendBits;
  logic [NUM_VEC-1:0]   vecMask;
  logic                 recheckStb;
  logic [VEC_IDX_W-1:0] recheckVec;
  msgStrobe_t           strobe;

  msixvt_datapath #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .pendBits   (pendBits),
    .strobe     (strobe),
    .vecMask    (vecMask),
    .recheckStb (recheckStb),
    .recheckVec (recheckVec),
    .msgAddr    (msgAddr),
    .msgData    (msgData)
  );

  msixvt_control #(.NUM_VEC(NUM_VEC)) ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .irqReq     (irqReq),
    .globalEn   (globalEn),
    .funcMask   (funcMask),
    .sweepReq   (sweepReq),
    .vecMask    (vecMask),
    .recheckStb (recheckStb),
    .recheckVec (recheckVec),
    .msgReady   (msgReady),
    .msgValid   (msgValid),
    .pendBits   (pendBits),
    .strobe     (strobe)
  );

endmodule

// File: rtl/msixvt_checker.sv
module msixvt_checker #(
  parameter int NUM_VEC = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_VEC-1:0] irqReq,
  input logic               globalEn,
  input logic               funcMask,
  input logic               sweepReq,
  input logic               msgValid,
  input logic               msgReady,
  input logic [63:0]        msgAddr,
  input logic [31:0]        msgData,
  input logic [NUM_VEC-1:0] pendBits,
  input logic [NUM_VEC-1:0] vecMask
);

  // R11
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgAddr[1:0] == 2'b00));

  generate
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
      // R6
      pend_on_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($rose(irqReq[g]) && globalEn && (funcMask || vecMask[g])) |=> pendBits[g]);

      // R8
      sweep_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
        (sweepReq && pendBits[g] && !vecMask[g] && !($rose(irqReq[g]) && globalEn))
          |=> !pendBits[g]);
    end
  endgenerate

endmodule

bind msixvt_top msixvt_checker #(.NUM_VEC(NUM_VEC)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .irqReq   (irqReq),
  .globalEn (globalEn),
  .funcMask (funcMask),
  .sweepReq (sweepReq),
  .msgValid (msgValid),
  .msgReady (msgReady),
  .msgAddr  (msgAddr),
  .msgData  (msgData),
  .pendBits (pendBits),
  .vecMask  (vecMask)
);

// File: tb/msixvt_top_tb_top.sv
`timescale 1ns/1ps
module msixvt_top_tb_top;

  localparam int NV = 8;
  localparam int AW = 16;
  localparam logic [15:0] PBA = 16'(NV * 16);

  logic          clk = 1'b0;
  logic          rstN;
  logic          busWrEn, busRdEn;
  logic [AW-1:0] busAddr;
  logic [31:0]   busWrData, busRdData;
  logic [NV-1:0] irqReq;
  logic          globalEn, funcMask, sweepReq;
  logic          msgValid, msgReady;
  logic [63:0]   msgAddr;
  logic [31:0]   msgData;

  always #2 clk = ~clk;  // 250 MHz

  msixvt_top #(.NUM_VEC(NV), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqReq(irqReq), .globalEn(globalEn), .funcMask(funcMask),
    .sweepReq(sweepReq), .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  int checks = 0;
  int failures = 0;
  int rxCount = 0;
  int cycles = 0;

  logic [31:0] mLo [NV];
  logic [31:0] mHi [NV];
  logic [31:0] mDat[NV];

  logic [63:0] expAddr[$];
  logic [31:0] expData[$];
  string       expTag [$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    chk(tag, 64'(d), 64'(exp));
  endtask

  task automatic progVec(input int v, input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] dat, input logic [31:0] ctl);
    busWrite(16'(v*16),     lo);
    busWrite(16'(v*16 + 4), hi);
    busWrite(16'(v*16 + 8), dat);
    busWrite(16'(v*16 + 12), ctl);
    mLo[v] = lo; mHi[v] = hi; mDat[v] = dat;
  endtask

  task automatic pushExp(input int v, input string tag);
    expAddr.push_back({mHi[v], mLo[v][31:2], 2'b00});
    expData.push_back(mDat[v]);
    expTag.push_back(tag);
  endtask

  task automatic setIrq(input logic [NV-1:0] val);
    @(posedge clk); #1;
    irqReq = val;
  endtask

  // Scoreboard monitor: handshake completes at the following rising edge
  always @(negedge clk) begin
    if (rstN && msgValid && msgReady) begin
      rxCount++;
      if (expAddr.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R5 unexpected message actual=%h/%h expected=none", msgAddr, msgData);
      end else begin
        chk(expTag[0], {msgAddr[31:0], msgData}, {expAddr[0][31:0], expData[0]});
        chk(expTag[0], 64'(msgAddr[63:32]), 64'(expAddr[0][63:32]));
        void'(expAddr.pop_front());
        void'(expData.pop_front());
        void'(expTag.pop_front());
      end
    end
  end

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finishRun();
    end
  end

  initial begin
    int rxBefore;
    rstN = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0; busAddr = '0; busWrData = '0;
    irqReq = '0; globalEn = 1'b0; funcMask = 1'b0; sweepReq = 1'b0; msgReady = 1'b1;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(1);

    // R1: reset contents
    chk("R1 valid", 64'(msgValid), 64'd0);
    for (int v = 0; v < NV; v++)
      for (int f = 0; f < 4; f++)
        rdChk("R1 table", 16'(v*16 + f*4), 32'h0);
    rdChk("R1 pending", PBA, 32'h0);

    // Program all entries; address low carries nonzero bits 1:0
    for (int v = 0; v < NV; v++)
      progVec(v, 32'h0000_1000 + 32'(v) * 32'h100 + 32'(v % 4),
              32'h0000_00A0 + 32'(v), 32'h5A00_0000 + 32'(v), 32'h0);

    // R2: field order and raw readback
    rdChk("R2 lo",   16'(3*16),      32'h0000_1303);
    rdChk("R2 hi",   16'(3*16 + 4),  32'h0000_00A3);
    rdChk("R2 data", 16'(3*16 + 8),  32'h5A00_0003);
    rdChk("R2 ctl",  16'(3*16 + 14), 32'h0);

    globalEn = 1'b1;

    // R3: basic delivery
    pushExp(2, "R3");
    setIrq(8'h04);
    waitCyc(8);
    chk("R3 drained", 64'(expAddr.size()), 64'd0);

    // R4: held level gives nothing more, new edge gives one more
    rxBefore = rxCount;
    waitCyc(8);
    chk("R4 held", 64'(rxCount), 64'(rxBefore));
    setIrq(8'h00);
    waitCyc(2);
    pushExp(2, "R4");
    setIrq(8'h04);
    waitCyc(8);
    chk("R4 re-edge", 64'(rxCount), 64'(rxBefore + 1));
    setIrq(8'h00);

    // R5: disabled requests ignored
    globalEn = 1'b0;
    rxBefore = rxCount;
    setIrq(8'h10);
    waitCyc(8);
    rdChk("R5 pending", PBA, 32'h0);
    chk("R5 no msg", 64'(rxCount), 64'(rxBefore));
    setIrq(8'h00);
    globalEn = 1'b1;
    waitCyc(2);

    // R6: vector mask and function mask record pending flags
    busWrite(16'(5*16 + 12), 32'h1);
    setIrq(8'h20);
    waitCyc(4);
    rdChk("R6 vec mask", PBA, 32'h20);
    funcMask = 1'b1;
    setIrq(8'h22);
    waitCyc(4);
    rdChk("R6 func mask", PBA, 32'h22);
    chk("R6 no msg", 64'(rxCount), 64'(rxBefore));
    funcMask = 1'b0;
    setIrq(8'h00);
    waitCyc(2);

    // R7: unmasking write releases vector 5
    pushExp(5, "R7");
    busWrite(16'(5*16 + 12), 32'h0);
    waitCyc(8);
    chk("R7 drained", 64'(expAddr.size()), 64'd0);
    rdChk("R7 pending", PBA, 32'h02);

    // R9: pending array is read-only
    busWrite(PBA, 32'hFFFF_FFFF);
    waitCyc(2);
    rdChk("R9 pending", PBA, 32'h02);
    busWrite(PBA + 16'd4, 32'h5);
    rdChk("R9 pad", PBA + 16'd4, 32'h0);

    // R8: sweep releases unmasked vector 1, keeps masked vector 6
    busWrite(16'(6*16 + 12), 32'h1);
    setIrq(8'h40);
    waitCyc(4);
    setIrq(8'h00);
    rdChk("R8 before", PBA, 32'h42);
    pushExp(1, "R8");
    @(posedge clk); #1; sweepReq = 1'b1;
    @(posedge clk); #1; sweepReq = 1'b0;
    waitCyc(8);
    chk("R8 drained", 64'(expAddr.size()), 64'd0);
    rdChk("R8 after", PBA, 32'h40);

    // R12: delivered request clears an older pending flag
    funcMask = 1'b1;
    setIrq(8'h01);
    waitCyc(4);
    setIrq(8'h00);
    funcMask = 1'b0;
    rdChk("R12 before", PBA, 32'h41);
    pushExp(0, "R12");
    setIrq(8'h01);
    waitCyc(8);
    rdChk("R12 after", PBA, 32'h40);
    setIrq(8'h00);
    waitCyc(2);

    // R11: simultaneous requests, ascending order, stall holds output
    msgReady = 1'b0;
    pushExp(0, "R11");
    pushExp(3, "R11");
    pushExp(7, "R11");
    setIrq(8'h89);
    waitCyc(6);
    @(negedge clk);
    chk("R11 valid", 64'(msgValid), 64'd1);
    chk("R11 head", msgAddr, expAddr[0]);
    waitCyc(3);
    @(negedge clk);
    chk("R11 stall", msgAddr, expAddr[0]);
    @(posedge clk); #1; msgReady = 1'b1;
    waitCyc(10);
    chk("R11 drained", 64'(expAddr.size()), 64'd0);
    setIrq(8'h00);

    // R10: region edges
    rdChk("R10 in region", 16'd4092, 32'h0);
    rdChk("R10 end", 16'd4096, 32'hFFFF_FFFF);
    rdChk("R10 far", 16'hFFFC, 32'hFFFF_FFFF);

    waitCyc(4);
    chk("R3 final queue", 64'(expAddr.size()), 64'd0);
    finishRun();
  end

endmodule